// File: doc/BRIEF.md
# Setup-Frame Perfect Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether each incoming frame is addressed to this station. It holds a table of sixteen exact-match 48-bit addresses. The table is filled from a 192-byte setup buffer that arrives as forty-eight 32-bit longwords on a load port. Each longword is tagged with a setup flag.

Inside the setup buffer, each table entry takes three consecutive longwords. Only the low half of each longword carries address bytes. The longwords are little-endian, so bits 7:0 hold the earlier address byte and bits 15:8 hold the later one. The upper half of each longword is padding.

Received destination addresses enter one byte per cycle. The first byte is marked with a start-of-frame flag. One clock after the sixth byte arrives, the block pulses a verdict that says whether the frame is accepted or rejected. A promiscuous-mode input makes every verdict an accept.

Top module: `perfect_da_filter`

## Requirements
- R1: After reset, `verdict_valid` and `verdict_accept` are 0 and all sixteen table entries read as zero.
- R2: A setup load consists of 48 setup-tagged longwords. Longwords 3k, 3k+1 and 3k+2 (counted from the start of the load) form entry k, for k = 0 to 15. A new complete load replaces every entry.
- R3: Longword w (0 to 2) of an entry supplies address byte 2w from bits 7:0 and address byte 2w+1 from bits 15:8. Address byte 0 is the first destination byte received.
- R4: Bits 31:16 of every setup longword have no effect on the table.
- R5: A longword presented without the setup flag neither changes the table nor advances the load position.
- R6: If promiscuous mode is off, a verdict accepts exactly when the six received bytes equal some loaded entry. A difference in any single byte gives a reject, and `verdict_accept` is never high without `verdict_valid`.
- R7: A byte with `da_valid` and `da_sof` starts a new address, discarding any partial one. The verdict is a one-cycle pulse in the cycle after the sixth valid byte. Valid bytes seen before any start marker, or after the sixth byte, are ignored. Idle cycles between bytes are allowed.
- R8: Until the first complete 48-longword load has finished, every verdict is a reject unless promiscuous mode is on, even for an all-zero address.
- R9: With `promisc` high in the cycle of the sixth byte, the verdict is an accept whatever the table holds.
- R10: While a load is partly done (1 to 47 setup longwords written), no verdict is issued for an address that completes in that interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | A longword is present on `setup_word` |
| setup_flag | input | 1 | The present longword belongs to a setup buffer |
| setup_word | input | 32 | Setup longword, little-endian |
| promisc | input | 1 | Accept every frame |
| da_valid | input | 1 | A destination byte is present on `da_byte` |
| da_sof | input | 1 | The present byte is the first byte of a frame |
| da_byte | input | 8 | Destination address byte |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | 1 = accept, 0 = reject; meaningful while `verdict_valid` is high |

## Verification
On every cycle, the assertions check the following:
- the table only moves on setup-tagged longwords;
- no verdict appears while a load is half done;
- promiscuous verdicts always accept;
- verdicts before the first full load reject;
- the verdict is a single-cycle pulse following a valid byte.

Other behaviour only the bench's scenarios can show. This covers which longword lands in which entry and byte, that the padding half is ignored, and that a one-byte difference rejects. It also covers restarting on a second start marker, ignoring stray bytes, and replacing the table on a second load. A behavioural reference model checks all of these cycle by cycle.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    localparam int NUM_ENTRIES     = 16;
    localparam int ADDR_BYTES      = 6;
    localparam int LW_WIDTH        = 32;
    localparam int BYTES_PER_LW    = 2;
    localparam int WORDS_PER_ENTRY = ADDR_BYTES / BYTES_PER_LW;
    localparam int SETUP_LONGWORDS = NUM_ENTRIES * WORDS_PER_ENTRY;
    localparam int ENT_W           = $clog2(NUM_ENTRIES);
    localparam int WRD_W           = $clog2(WORDS_PER_ENTRY);
    localparam int BIDX_W          = $clog2(ADDR_BYTES + 1);
    localparam int MAC_W           = ADDR_BYTES * 8;

    typedef logic [7:0] octet_t;

    // element 0 is the first byte on the wire
    typedef octet_t [ADDR_BYTES-1:0] mac_t;

    // one table write: two address bytes into one word slot of one entry
    typedef struct packed {
        logic             en;
        logic [ENT_W-1:0] entry;
        logic [WRD_W-1:0] word;
        octet_t           lo;
        octet_t           hi;
    } tbl_wr_t;

    typedef enum logic [1:0] {
        COL_IDLE   = 2'd0,
        COL_GATHER = 2'd1,
        COL_DONE   = 2'd2
    } col_state_e;

    function automatic logic last_slot(input logic [ENT_W-1:0] ent,
                                       input logic [WRD_W-1:0] wrd);
        return (ent == ENT_W'(NUM_ENTRIES - 1)) &&
               (wrd == WRD_W'(WORDS_PER_ENTRY - 1));
    endfunction

endpackage

// File: rtl/pdf_setup_loader.sv
module pdf_setup_loader
    import pdf_pkg::*;
#(
    parameter int NENT = NUM_ENTRIES,
    parameter int NWRD = WORDS_PER_ENTRY
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lw_valid,
    input  logic                lw_setup,
    input  logic [LW_WIDTH-1:0] lw_data,
    output tbl_wr_t             wr,
    output logic                busy,
    output logic                loaded
);

    logic [ENT_W-1:0] ent_q;
    logic [WRD_W-1:0] wrd_q;
    logic             take;
    logic             at_end;

    assign take   = lw_valid && lw_setup;
    assign at_end = last_slot(ent_q, wrd_q);

    always_comb begin
        wr.en    = take;
        wr.entry = ent_q;
        wr.word  = wrd_q;
        wr.lo    = lw_data[7:0];
        wr.hi    = lw_data[15:8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q  <= '0;
            wrd_q  <= '0;
            loaded <= 1'b0;
        end else if (take) begin
            if (wrd_q == WRD_W'(NWRD - 1)) begin
                wrd_q <= '0;
                ent_q <= at_end ? '0 : ent_q + 1'b1;
            end else begin
                wrd_q <= wrd_q + 1'b1;
            end
            if (at_end) begin
                loaded <= 1'b1;
            end
        end
    end

    assign busy = (ent_q != '0) || (wrd_q != '0);

endmodule

// File: rtl/pdf_addr_table.sv
module pdf_addr_table
    import pdf_pkg::*;
#(
    parameter int NENT = NUM_ENTRIES,
    parameter int NWRD = WORDS_PER_ENTRY
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tbl_wr_t               wr,
    input  mac_t                  cand,
    output logic [NENT-1:0]       hits,
    output logic [NENT*MAC_W-1:0] tbl_flat
);

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        mac_t ent_q;
        for (genvar w = 0; w < NWRD; w++) begin : g_wrd
            logic sel;
            assign sel = wr.en && (wr.entry == ENT_W'(e)) &&
                         (wr.word == WRD_W'(w));
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[2*w]   <= '0;
                    ent_q[2*w+1] <= '0;
                end else if (sel) begin
                    ent_q[2*w]   <= wr.lo;
                    ent_q[2*w+1] <= wr.hi;
                end
            end
        end
        assign hits[e] = (ent_q == cand);
        assign tbl_flat[e*MAC_W +: MAC_W] = ent_q;
    end

endmodule

// File: rtl/pdf_da_collector.sv
module pdf_da_collector
    import pdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   da_valid,
    input  logic   da_sof,
    input  octet_t da_byte,
    output mac_t   cand,
    output logic   fire
);

    col_state_e        st_q;
    logic [BIDX_W-1:0] idx_q;
    mac_t              held_q;
    logic              final_byte;

    assign final_byte = (st_q == COL_GATHER) && (idx_q == BIDX_W'(ADDR_BYTES - 1));
    assign fire       = da_valid && !da_sof && final_byte;

    always_comb begin
        cand = held_q;
        cand[ADDR_BYTES-1] = da_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= COL_IDLE;
            idx_q  <= '0;
            held_q <= '0;
        end else if (da_valid) begin
            if (da_sof) begin
                held_q[0] <= da_byte;
                idx_q     <= BIDX_W'(1);
                st_q      <= COL_GATHER;
            end else if (st_q == COL_GATHER) begin
                held_q[idx_q] <= da_byte;
                idx_q         <= idx_q + 1'b1;
                if (final_byte) begin
                    st_q <= COL_DONE;
                end
            end
        end
    end

endmodule

// File: rtl/pdf_verdict.sv
module pdf_verdict
    import pdf_pkg::*;
#(
    parameter int NENT = NUM_ENTRIES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic            busy,
    input  logic            loaded,
    input  logic            promisc,
    input  logic [NENT-1:0] hits,
    output logic            v_valid,
    output logic            v_accept
);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_valid  <= 1'b0;
            v_accept <= 1'b0;
        end else if (fire && !busy) begin
            v_valid  <= 1'b1;
            v_accept <= promisc || (loaded && (|hits));
        end else begin
            v_valid  <= 1'b0;
            v_accept <= 1'b0;
        end
    end

endmodule

// File: rtl/perfect_da_filter.sv
module perfect_da_filter
    import pdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        setup_valid,
    input  logic        setup_flag,
    input  logic [31:0] setup_word,
    input  logic        promisc,
    input  logic        da_valid,
    input  logic        da_sof,
    input  logic [7:0]  da_byte,
    output logic        verdict_valid,
    output logic        verdict_accept
);

    tbl_wr_t                      wr;
    logic                         busy;
    logic                         loaded;
    mac_t                         cand;
    logic                         fire;
    logic [NUM_ENTRIES-1:0]       hits;
    logic [NUM_ENTRIES*MAC_W-1:0] tbl_flat;

    pdf_setup_loader #(
        .NENT (NUM_ENTRIES),
        .NWRD (WORDS_PER_ENTRY)
    ) u_loader (
        .clk      (clk),
        .rst      (rst),
        .lw_valid (setup_valid),
        .lw_setup (setup_flag),
        .lw_data  (setup_word),
        .wr       (wr),
        .busy     (busy),
        .loaded   (loaded)
    );

    pdf_addr_table #(
        .NENT (NUM_ENTRIES),
        .NWRD (WORDS_PER_ENTRY)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .cand     (cand),
        .hits     (hits),
        .tbl_flat (tbl_flat)
    );

    pdf_da_collector u_collect (
        .clk      (clk),
        .rst      (rst),
        .da_valid (da_valid),
        .da_sof   (da_sof),
        .da_byte  (da_byte),
        .cand     (cand),
        .fire     (fire)
    );

    pdf_verdict #(
        .NENT (NUM_ENTRIES)
    ) u_verdict (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .busy     (busy),
        .loaded   (loaded),
        .promisc  (promisc),
        .hits     (hits),
        .v_valid  (verdict_valid),
        .v_accept (verdict_accept)
    );

endmodule

// File: rtl/pdf_checker.sv
module pdf_checker
    import pdf_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         setup_valid,
    input logic                         setup_flag,
    input logic                         promisc,
    input logic                         da_valid,
    input logic                         verdict_valid,
    input logic                         verdict_accept,
    input logic                         busy,
    input logic                         loaded,
    input logic [NUM_ENTRIES*MAC_W-1:0] tbl_flat
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!verdict_valid && !verdict_accept));

    // R5
    table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(setup_valid && setup_flag) |-> $stable(tbl_flat));

    // R6
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> verdict_valid);

    // R7
    verdict_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(da_valid));

    // R7
    verdict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);

    // R8
    unloaded_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !$past(promisc) && !$past(loaded)) |-> !verdict_accept);

    // R9
    promisc_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && $past(promisc)) |-> verdict_accept);

    // R10
    load_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !verdict_valid);

endmodule

bind perfect_da_filter pdf_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .setup_valid    (setup_valid),
    .setup_flag     (setup_flag),
    .promisc        (promisc),
    .da_valid       (da_valid),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .busy           (busy),
    .loaded         (loaded),
    .tbl_flat       (tbl_flat)
);

// File: tb/perfect_da_filter_test.sv
module perfect_da_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        setup_valid = 1'b0;
    logic        setup_flag = 1'b0;
    logic [31:0] setup_word = '0;
    logic        promisc = 1'b0;
    logic        da_valid = 1'b0;
    logic        da_sof = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        verdict_valid;
    logic        verdict_accept;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;  // 50 MHz

    perfect_da_filter uut (
        .clk            (clk),
        .rst            (rst),
        .setup_valid    (setup_valid),
        .setup_flag     (setup_flag),
        .setup_word     (setup_word),
        .promisc        (promisc),
        .da_valid       (da_valid),
        .da_sof         (da_sof),
        .da_byte        (da_byte),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_tbl [16][6];
    int         m_cnt;
    bit         m_loaded;
    int         m_idx;
    logic [7:0] m_cb [6];
    bit         e_v, e_a;

    always @(posedge clk) begin : model
        bit busy, hit, same;
        int ent, wd;
        if (rst) begin
            for (int e = 0; e < 16; e++)
                for (int b = 0; b < 6; b++) m_tbl[e][b] = 8'h00;
            m_cnt = 0; m_loaded = 0; m_idx = 0; e_v = 0; e_a = 0;
        end else begin
            busy = (m_cnt != 0);
            e_v = 0; e_a = 0;
            if (da_valid) begin
                if (da_sof) begin
                    m_cb[0] = da_byte; m_idx = 1;
                end else if (m_idx >= 1 && m_idx <= 5) begin
                    m_cb[m_idx] = da_byte;
                    m_idx = m_idx + 1;
                    if (m_idx == 6 && !busy) begin
                        hit = 0;
                        for (int e = 0; e < 16; e++) begin
                            same = 1;
                            for (int b = 0; b < 6; b++)
                                if (m_tbl[e][b] != m_cb[b]) same = 0;
                            if (same) hit = 1;
                        end
                        e_v = 1;
                        e_a = promisc || (m_loaded && hit);
                    end
                end
            end
            if (setup_valid && setup_flag) begin
                ent = m_cnt / 3; wd = m_cnt % 3;
                m_tbl[ent][2*wd]   = setup_word[7:0];
                m_tbl[ent][2*wd+1] = setup_word[15:8];
                m_cnt = m_cnt + 1;
                if (m_cnt == 48) begin m_cnt = 0; m_loaded = 1; end
            end
        end
    end

    // compare the design against the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            compared++;
            if (verdict_valid !== e_v || verdict_accept !== e_a) begin
                mismatched++;
                $display("FAIL %s per-cycle: actual v=%b a=%b expected v=%b a=%b",
                         cur_req, verdict_valid, verdict_accept, e_v, e_a);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit exp_v, input bit exp_a, input string tag);
        compared++;
        if (verdict_valid !== exp_v || verdict_accept !== exp_a) begin
            mismatched++;
            $display("FAIL %s: actual v=%b a=%b expected v=%b a=%b",
                     tag, verdict_valid, verdict_accept, exp_v, exp_a);
        end
    endtask

    function automatic logic [47:0] mk(input int k, input logic [7:0] salt);
        return {8'h02, salt, 8'h3C, 8'h10, 8'(k), 8'(8'h5A ^ 8'(k))};
    endfunction

    task automatic push_lw(input logic [31:0] d, input bit flag);
        @(negedge clk);
        setup_valid = 1'b1; setup_flag = flag; setup_word = d;
        @(negedge clk);
        setup_valid = 1'b0; setup_flag = 1'b0;
    endtask

    // longword w of entry holding mac; upper half is padding (R4)
    function automatic logic [31:0] lw_of(input logic [47:0] mac, input int w, input int n);
        logic [15:0] pad;
        pad = 16'hBEEF ^ 16'(n * 16'h1357);
        return {pad, mac[39-16*w -: 8], mac[47-16*w -: 8]};
    endfunction

    task automatic send_da(input logic [47:0] mac, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = (i == 0); da_byte = mac[47-8*i -: 8];
            if (gaps && i < 5) begin
                @(negedge clk);
                da_valid = 1'b0; da_sof = 1'b0;
            end
        end
        @(negedge clk);
        da_valid = 1'b0; da_sof = 1'b0;
    endtask

    task automatic stray_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = 1'b0; da_byte = 8'(8'hA0 + i);
        end
        @(negedge clk);
        da_valid = 1'b0;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R7 watchdog: actual still running after 150000 cycles, expected completion");
        finish_up();
    end

    logic [47:0] tab_a [16];
    logic [47:0] tab_b [16];

    initial begin : main
        int n;
        for (int k = 0; k < 16; k++) begin
            tab_a[k] = (k == 0) ? 48'hFFFF_FFFF_FFFF : mk(k, 8'h11);
            tab_b[k] = mk(k, 8'h77);
        end
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check(1'b0, 1'b0, "R1 reset outputs");
        rst = 1'b0;

        // R8: zero table not yet loaded must not match zero address
        cur_req = "R8";
        send_da(48'h0, 1'b0);
        check(1'b1, 1'b0, "R8 zero address before load");

        // R9: promiscuous accepts anything
        cur_req = "R9";
        promisc = 1'b1;
        send_da(48'h1234_5678_9ABC, 1'b0);
        check(1'b1, 1'b1, "R9 promiscuous accept");
        promisc = 1'b0;

        // R10: partial load blocks verdict, also in promiscuous mode
        cur_req = "R10";
        n = 0;
        for (int lw = 0; lw < 10; lw++) begin
            push_lw(lw_of(tab_a[lw/3], lw%3, n), 1'b1); n++;
        end
        promisc = 1'b1;
        send_da(tab_a[1], 1'b0);
        check(1'b0, 1'b0, "R10 verdict blocked mid-load");
        promisc = 1'b0;

        // R5: untagged longwords interleaved do not advance or write
        cur_req = "R5";
        for (int lw = 10; lw < 48; lw++) begin
            if (lw % 7 == 0) push_lw(32'hDEAD_C0DE ^ 32'(lw), 1'b0);
            push_lw(lw_of(tab_a[lw/3], lw%3, n), 1'b1); n++;
        end

        // R2 R3 R4 R6: every entry accepted
        cur_req = "R2";
        for (int k = 0; k < 16; k++) begin
            send_da(tab_a[k], 1'b0);
            check(1'b1, 1'b1, $sformatf("R2 R3 R4 entry %0d accepted", k));
        end

        cur_req = "R6";
        send_da(tab_a[5] ^ 48'h0000_0000_0001, 1'b0);
        check(1'b1, 1'b0, "R6 last byte differs");
        send_da(tab_a[9] ^ 48'h8000_0000_0000, 1'b0);
        check(1'b1, 1'b0, "R6 first byte differs");
        send_da(48'hFFFF_FFFF_FFFE, 1'b0);
        check(1'b1, 1'b0, "R6 near broadcast");

        // R5: untagged longwords after load leave table intact
        cur_req = "R5";
        push_lw(32'h0000_0000, 1'b0);
        push_lw(32'h0000_0000, 1'b0);
        push_lw(32'h0000_0000, 1'b0);
        send_da(48'h0, 1'b0);
        check(1'b1, 1'b0, "R5 untagged zeros not written");
        send_da(tab_a[0], 1'b0);
        check(1'b1, 1'b1, "R5 entry 0 intact");

        // R7: gaps, stray bytes, restart on second marker
        cur_req = "R7";
        send_da(tab_a[3], 1'b1);
        check(1'b1, 1'b1, "R7 gapped bytes");
        stray_bytes(8);
        check(1'b0, 1'b0, "R7 stray bytes no verdict");
        @(negedge clk);
        da_valid = 1'b1; da_sof = 1'b1; da_byte = 8'h55;
        @(negedge clk);
        da_sof = 1'b0; da_byte = 8'h66;
        @(negedge clk);
        da_valid = 1'b0;
        send_da(tab_a[7], 1'b0);
        check(1'b1, 1'b1, "R7 restart after abandoned address");
        stray_bytes(3);
        check(1'b0, 1'b0, "R7 bytes after sixth ignored");

        // R2: complete reload replaces table
        cur_req = "R2";
        for (int lw = 0; lw < 48; lw++) begin
            push_lw(lw_of(tab_b[lw/3], lw%3, lw + 5), 1'b1);
        end
        send_da(tab_a[4], 1'b0);
        check(1'b1, 1'b0, "R2 old entry gone after reload");
        send_da(tab_b[15], 1'b0);
        check(1'b1, 1'b1, "R2 new last entry");
        send_da(tab_b[0], 1'b0);
        check(1'b1, 1'b1, "R3 new first entry");

        // R9 again with a loaded table and a non-matching address
        cur_req = "R9";
        promisc = 1'b1;
        send_da(48'h0102_0304_0506, 1'b1);
        check(1'b1, 1'b1, "R9 promiscuous over loaded table");
        promisc = 1'b0;

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule